// File: doc/BRIEF.md
# Staged Packet Filter Chain

This block is one firewall filter in a packet path. Each packet arrives as a header record that an earlier parser has already extracted, tagged with a flow number of up to 15 bits (32768 flows). The filter checks that record against a rule record for its flow and returns a verdict of accept, drop or modify. It also returns a short log record for every packet.

A small intake state machine pairs one rule with one header. In `ST_WAIT_RULE` the block raises `rule_ready`. A rule handshake latches the rule and takes the transition `RULE_TAKEN` to `ST_ARMED`. In `ST_ARMED` the block raises `hdr_ready` and keeps it high until a header arrives. The header handshake launches the pair into the check pipeline and takes the transition `HDR_TAKEN` back to `ST_WAIT_RULE`. While `ST_ARMED` waits for a header, it loops on the transition `ARMED_IDLE`.

The pipeline has three registered stages, in a fixed order:
- The link stage checks the MAC addresses, the VLAN and the ethertype.
- The network stage checks the exact IP addresses and runs an anti-spoof prefix test on the source address.
- The transport stage checks the protocol and the two port ranges.

The first stage that fails marks the packet with its layer code, and the later stages carry that mark forward unchanged.

Top module: `pkt_filter_chain`

## Requirements
- R1: After reset the block is in `ST_WAIT_RULE` with `rule_ready`=1 and `hdr_ready`=0. A rule handshake moves it to `ST_ARMED`, where `hdr_ready`=1 and `rule_ready`=0. `hdr_ready` stays high for any number of idle cycles until a header handshake, which returns the block to `ST_WAIT_RULE`. The two ready signals are never high together.
- R2: Suppose a header handshake is sampled at clock edge E. Then `out_valid` is high for exactly the one cycle that follows edge E+2, and it is low in the cycles between.
- R3: Enable bits 0 to 3 of `rule_en` select exact compares of source MAC, destination MAC, VLAN and ethertype. Any enabled mismatch gives drop (`out_verdict`=2'b01) with `out_layer`=1.
- R4: Enable bits 4 and 5 select exact compares of source and destination IP. An enabled mismatch gives drop with `out_layer`=2.
- R5: Enable bit 6 selects the anti-spoof test. It passes only when (source IP & `rule_mask`) equals `rule_pfx`; otherwise the result is drop with `out_layer`=2.
- R6: Enable bit 7 selects an exact protocol compare. Bits 8 and 9 select the inclusive ranges [lo, hi] for source and destination port. A mismatch or an out-of-range port gives drop with `out_layer`=3.
- R7: When several layers fail, `out_layer` names the lowest failing layer. `out_layer` is nonzero exactly when the verdict is drop.
- R8: A check whose enable bit is cleared has no effect, whatever the rule and header values in that field.
- R9: When every enabled check passes, the verdict is modify (2'b10) if `rule_rewrite`=1 and accept (2'b00) otherwise, with `out_layer`=0. The code 2'b11 never appears.
- R10: `out_flow` equals the flow number of the header that produced the verdict.
- R11: During reset and until the first result, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rule_valid | input | 1 | Rule record offered |
| rule_ready | output | 1 | Block can take a rule |
| rule_en | input | 10 | Per-check enable bits (see R3 to R6) |
| rule_rewrite | input | 1 | Request modify when all checks pass |
| rule_smac | input | 48 | Expected source MAC |
| rule_dmac | input | 48 | Expected destination MAC |
| rule_vlan | input | 12 | Expected VLAN ID |
| rule_etype | input | 16 | Expected ethertype |
| rule_sip | input | 32 | Expected source IP |
| rule_dip | input | 32 | Expected destination IP |
| rule_pfx | input | 32 | Allowed source prefix |
| rule_mask | input | 32 | Mask for the prefix test |
| rule_proto | input | 8 | Expected protocol number |
| rule_sport_lo | input | 16 | Source port lower bound |
| rule_sport_hi | input | 16 | Source port upper bound |
| rule_dport_lo | input | 16 | Destination port lower bound |
| rule_dport_hi | input | 16 | Destination port upper bound |
| hdr_valid | input | 1 | Header record offered |
| hdr_ready | output | 1 | Block can take a header |
| hdr_flow | input | 15 | Flow number |
| hdr_smac | input | 48 | Source MAC |
| hdr_dmac | input | 48 | Destination MAC |
| hdr_vlan | input | 12 | VLAN ID |
| hdr_etype | input | 16 | Ethertype |
| hdr_sip | input | 32 | Source IP |
| hdr_dip | input | 32 | Destination IP |
| hdr_proto | input | 8 | Protocol number |
| hdr_sport | input | 16 | Source port |
| hdr_dport | input | 16 | Destination port |
| out_valid | output | 1 | Verdict and log valid |
| out_verdict | output | 2 | 00 accept, 01 drop, 10 modify |
| out_layer | output | 2 | Failing layer, 0 none, 1 link, 2 network, 3 transport |
| out_flow | output | 15 | Flow number for the log |

## Verification
On every cycle, the assertions check the following:
- the two ready signals are exclusive;
- `hdr_ready` holds while the block is armed;
- the fixed three-edge latency from a header handshake to `out_valid`;
- the echo of the flow number;
- the legal verdict codes;
- the agreement between a drop verdict and a nonzero layer code.

Only the bench scenarios can show that each field compare, prefix test and port range gives the right verdict. Those scenarios also cover the inclusive port boundaries, the lowest-failing-layer priority, the wildcard behaviour and the choice between modify and accept. The bench checks these against a model of the rules.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

    parameter int FLOW_W  = 15;
    parameter int MAC_W   = 48;
    parameter int VLAN_W  = 12;
    parameter int ETYPE_W = 16;
    parameter int IP_W    = 32;
    parameter int PROTO_W = 8;
    parameter int PORT_W  = 16;
    parameter int EN_W    = 10;

    // enable bit positions inside the rule enable vector
    localparam int EN_SMAC  = 0;
    localparam int EN_DMAC  = 1;
    localparam int EN_VLAN  = 2;
    localparam int EN_ETYPE = 3;
    localparam int EN_SIP   = 4;
    localparam int EN_DIP   = 5;
    localparam int EN_SPOOF = 6;
    localparam int EN_PROTO = 7;
    localparam int EN_SPORT = 8;
    localparam int EN_DPORT = 9;

    typedef enum logic [1:0] {
        VD_ACCEPT = 2'b00,
        VD_DROP   = 2'b01,
        VD_MODIFY = 2'b10
    } verdict_e;

    localparam logic [1:0] LY_NONE = 2'd0;

    typedef struct packed {
        logic [FLOW_W-1:0]  flow;
        logic [MAC_W-1:0]   smac;
        logic [MAC_W-1:0]   dmac;
        logic [VLAN_W-1:0]  vlan;
        logic [ETYPE_W-1:0] etype;
        logic [IP_W-1:0]    sip;
        logic [IP_W-1:0]    dip;
        logic [PROTO_W-1:0] proto;
        logic [PORT_W-1:0]  sport;
        logic [PORT_W-1:0]  dport;
    } hdr_t;

    typedef struct packed {
        logic [EN_W-1:0]    en;
        logic               rewrite;
        logic [MAC_W-1:0]   smac;
        logic [MAC_W-1:0]   dmac;
        logic [VLAN_W-1:0]  vlan;
        logic [ETYPE_W-1:0] etype;
        logic [IP_W-1:0]    sip;
        logic [IP_W-1:0]    dip;
        logic [IP_W-1:0]    pfx;
        logic [IP_W-1:0]    mask;
        logic [PROTO_W-1:0] proto;
        logic [PORT_W-1:0]  sport_lo;
        logic [PORT_W-1:0]  sport_hi;
        logic [PORT_W-1:0]  dport_lo;
        logic [PORT_W-1:0]  dport_hi;
    } rule_t;

    typedef struct packed {
        logic       valid;
        logic [1:0] fail;
        hdr_t       hdr;
        rule_t      rule;
    } slot_t;

endpackage

// File: rtl/pfc_rule_intake.sv
module pfc_rule_intake
    import pfc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  rule_valid,
    input  rule_t rule_i,
    input  logic  hdr_valid,
    output logic  rule_ready,
    output logic  hdr_ready,
    output logic  launch,
    output rule_t rule_o
);

    typedef enum logic {
        ST_WAIT_RULE = 1'b0,
        ST_ARMED     = 1'b1
    } intake_e;

    intake_e state_q;
    intake_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT_RULE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: RULE_TAKEN, ARMED_IDLE, HDR_TAKEN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_RULE: if (rule_valid) state_d = ST_ARMED;
            ST_ARMED:     if (hdr_valid)  state_d = ST_WAIT_RULE;
            default:      state_d = ST_WAIT_RULE;
        endcase
    end

    // outputs
    always_comb begin
        rule_ready = 1'b0;
        hdr_ready  = 1'b0;
        launch     = 1'b0;
        unique case (state_q)
            ST_WAIT_RULE: rule_ready = 1'b1;
            ST_ARMED: begin
                hdr_ready = 1'b1;
                launch    = hdr_valid;
            end
            default: ;
        endcase
    end

    // held rule record
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rule_o <= '0;
        end else if (state_q == ST_WAIT_RULE && rule_valid) begin
            rule_o <= rule_i;
        end
    end

endmodule

// File: rtl/pfc_layer_stage.sv
module pfc_layer_stage
    import pfc_pkg::*;
#(
    parameter int LAYER = 1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  slot_t slot_i,
    output slot_t slot_o
);

    localparam logic [1:0] CODE = 2'(LAYER);

    logic layer_ok;

    function automatic logic in_range(input logic [PORT_W-1:0] v,
                                      input logic [PORT_W-1:0] lo,
                                      input logic [PORT_W-1:0] hi);
        return (v >= lo) && (v <= hi);
    endfunction

    generate
        if (LAYER == 1) begin : g_link
            assign layer_ok =
                (!slot_i.rule.en[EN_SMAC]  || slot_i.hdr.smac  == slot_i.rule.smac)  &&
                (!slot_i.rule.en[EN_DMAC]  || slot_i.hdr.dmac  == slot_i.rule.dmac)  &&
                (!slot_i.rule.en[EN_VLAN]  || slot_i.hdr.vlan  == slot_i.rule.vlan)  &&
                (!slot_i.rule.en[EN_ETYPE] || slot_i.hdr.etype == slot_i.rule.etype);
        end else if (LAYER == 2) begin : g_net
            assign layer_ok =
                (!slot_i.rule.en[EN_SIP]   || slot_i.hdr.sip == slot_i.rule.sip) &&
                (!slot_i.rule.en[EN_DIP]   || slot_i.hdr.dip == slot_i.rule.dip) &&
                (!slot_i.rule.en[EN_SPOOF] ||
                    ((slot_i.hdr.sip & slot_i.rule.mask) == slot_i.rule.pfx));
        end else begin : g_xport
            assign layer_ok =
                (!slot_i.rule.en[EN_PROTO] || slot_i.hdr.proto == slot_i.rule.proto) &&
                (!slot_i.rule.en[EN_SPORT] ||
                    in_range(slot_i.hdr.sport, slot_i.rule.sport_lo, slot_i.rule.sport_hi)) &&
                (!slot_i.rule.en[EN_DPORT] ||
                    in_range(slot_i.hdr.dport, slot_i.rule.dport_lo, slot_i.rule.dport_hi));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_o <= '0;
        end else begin
            slot_o <= slot_i;
            if (slot_i.valid && slot_i.fail == LY_NONE && !layer_ok) begin
                slot_o.fail <= CODE;
            end
        end
    end

endmodule

// File: rtl/pkt_filter_chain.sv
module pkt_filter_chain
    import pfc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rule_valid,
    output logic               rule_ready,
    input  logic [EN_W-1:0]    rule_en,
    input  logic               rule_rewrite,
    input  logic [MAC_W-1:0]   rule_smac,
    input  logic [MAC_W-1:0]   rule_dmac,
    input  logic [VLAN_W-1:0]  rule_vlan,
    input  logic [ETYPE_W-1:0] rule_etype,
    input  logic [IP_W-1:0]    rule_sip,
    input  logic [IP_W-1:0]    rule_dip,
    input  logic [IP_W-1:0]    rule_pfx,
    input  logic [IP_W-1:0]    rule_mask,
    input  logic [PROTO_W-1:0] rule_proto,
    input  logic [PORT_W-1:0]  rule_sport_lo,
    input  logic [PORT_W-1:0]  rule_sport_hi,
    input  logic [PORT_W-1:0]  rule_dport_lo,
    input  logic [PORT_W-1:0]  rule_dport_hi,
    input  logic               hdr_valid,
    output logic               hdr_ready,
    input  logic [FLOW_W-1:0]  hdr_flow,
    input  logic [MAC_W-1:0]   hdr_smac,
    input  logic [MAC_W-1:0]   hdr_dmac,
    input  logic [VLAN_W-1:0]  hdr_vlan,
    input  logic [ETYPE_W-1:0] hdr_etype,
    input  logic [IP_W-1:0]    hdr_sip,
    input  logic [IP_W-1:0]    hdr_dip,
    input  logic [PROTO_W-1:0] hdr_proto,
    input  logic [PORT_W-1:0]  hdr_sport,
    input  logic [PORT_W-1:0]  hdr_dport,
    output logic               out_valid,
    output logic [1:0]         out_verdict,
    output logic [1:0]         out_layer,
    output logic [FLOW_W-1:0]  out_flow
);

    localparam int NUM_STAGES = 3;

    rule_t rule_in;
    rule_t rule_held;
    hdr_t  hdr_in;
    logic  launch;
    slot_t slots [NUM_STAGES+1];

    always_comb begin
        rule_in          = '0;
        rule_in.en       = rule_en;
        rule_in.rewrite  = rule_rewrite;
        rule_in.smac     = rule_smac;
        rule_in.dmac     = rule_dmac;
        rule_in.vlan     = rule_vlan;
        rule_in.etype    = rule_etype;
        rule_in.sip      = rule_sip;
        rule_in.dip      = rule_dip;
        rule_in.pfx      = rule_pfx;
        rule_in.mask     = rule_mask;
        rule_in.proto    = rule_proto;
        rule_in.sport_lo = rule_sport_lo;
        rule_in.sport_hi = rule_sport_hi;
        rule_in.dport_lo = rule_dport_lo;
        rule_in.dport_hi = rule_dport_hi;
    end

    always_comb begin
        hdr_in       = '0;
        hdr_in.flow  = hdr_flow;
        hdr_in.smac  = hdr_smac;
        hdr_in.dmac  = hdr_dmac;
        hdr_in.vlan  = hdr_vlan;
        hdr_in.etype = hdr_etype;
        hdr_in.sip   = hdr_sip;
        hdr_in.dip   = hdr_dip;
        hdr_in.proto = hdr_proto;
        hdr_in.sport = hdr_sport;
        hdr_in.dport = hdr_dport;
    end

    pfc_rule_intake intake_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rule_valid (rule_valid),
        .rule_i     (rule_in),
        .hdr_valid  (hdr_valid),
        .rule_ready (rule_ready),
        .hdr_ready  (hdr_ready),
        .launch     (launch),
        .rule_o     (rule_held)
    );

    always_comb begin
        slots[0].valid = launch;
        slots[0].fail  = LY_NONE;
        slots[0].hdr   = hdr_in;
        slots[0].rule  = rule_held;
    end

    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
        pfc_layer_stage #(.LAYER(s + 1)) stage_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .slot_i (slots[s]),
            .slot_o (slots[s+1])
        );
    end

    // verdict and log record from the last stage register
    always_comb begin
        out_valid   = slots[NUM_STAGES].valid;
        out_layer   = slots[NUM_STAGES].fail;
        out_flow    = slots[NUM_STAGES].hdr.flow;
        out_verdict = VD_ACCEPT;
        if (!slots[NUM_STAGES].valid) begin
            out_layer = LY_NONE;
        end else if (slots[NUM_STAGES].fail != LY_NONE) begin
            out_verdict = VD_DROP;
        end else if (slots[NUM_STAGES].rule.rewrite) begin
            out_verdict = VD_MODIFY;
        end
    end

endmodule

// File: rtl/pfc_chain_checker.sv
module pfc_chain_checker
    import pfc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              rule_ready,
    input logic              hdr_valid,
    input logic              hdr_ready,
    input logic [FLOW_W-1:0] hdr_flow,
    input logic              out_valid,
    input logic [1:0]        out_verdict,
    input logic [1:0]        out_layer,
    input logic [FLOW_W-1:0] out_flow
);

    AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rule_ready && hdr_ready)); // R1

    AST_ARMED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_ready && !hdr_valid) |=> hdr_ready); // R1

    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_ready) |-> ##3 out_valid); // R2

    AST_RESULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(hdr_valid && hdr_ready, 3)); // R2

    AST_FLOW_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_flow == $past(hdr_flow, 3))); // R10

    AST_VERDICT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_verdict != 2'b11)); // R9

    AST_DROP_HAS_LAYER: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_verdict == 2'b01) == (out_layer != 2'b00))); // R7

endmodule

bind pkt_filter_chain pfc_chain_checker checker_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rule_ready  (rule_ready),
    .hdr_valid   (hdr_valid),
    .hdr_ready   (hdr_ready),
    .hdr_flow    (hdr_flow),
    .out_valid   (out_valid),
    .out_verdict (out_verdict),
    .out_layer   (out_layer),
    .out_flow    (out_flow)
);

// File: tb/pkt_filter_chain_tb_top.sv
`timescale 1ns/1ps
module pkt_filter_chain_tb_top;
    import pfc_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    hdr_t  h_drv;
    rule_t r_drv;
    logic  rule_valid = 1'b0;
    logic  hdr_valid = 1'b0;
    logic  rule_ready, hdr_ready, out_valid;
    logic [1:0] out_verdict, out_layer;
    logic [FLOW_W-1:0] out_flow;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    pkt_filter_chain dut_i (
        .clk(clk), .rst_n(rst_n),
        .rule_valid(rule_valid), .rule_ready(rule_ready),
        .rule_en(r_drv.en), .rule_rewrite(r_drv.rewrite),
        .rule_smac(r_drv.smac), .rule_dmac(r_drv.dmac),
        .rule_vlan(r_drv.vlan), .rule_etype(r_drv.etype),
        .rule_sip(r_drv.sip), .rule_dip(r_drv.dip),
        .rule_pfx(r_drv.pfx), .rule_mask(r_drv.mask),
        .rule_proto(r_drv.proto),
        .rule_sport_lo(r_drv.sport_lo), .rule_sport_hi(r_drv.sport_hi),
        .rule_dport_lo(r_drv.dport_lo), .rule_dport_hi(r_drv.dport_hi),
        .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
        .hdr_flow(h_drv.flow), .hdr_smac(h_drv.smac), .hdr_dmac(h_drv.dmac),
        .hdr_vlan(h_drv.vlan), .hdr_etype(h_drv.etype),
        .hdr_sip(h_drv.sip), .hdr_dip(h_drv.dip), .hdr_proto(h_drv.proto),
        .hdr_sport(h_drv.sport), .hdr_dport(h_drv.dport),
        .out_valid(out_valid), .out_verdict(out_verdict),
        .out_layer(out_layer), .out_flow(out_flow)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // model of the rule checks
    function automatic void model(input hdr_t h, input rule_t r,
                                  output logic [1:0] v, output logic [1:0] l);
        bit f2, f3, f4;
        f2 = (r.en[0] && h.smac != r.smac) || (r.en[1] && h.dmac != r.dmac) ||
             (r.en[2] && h.vlan != r.vlan) || (r.en[3] && h.etype != r.etype);
        f3 = (r.en[4] && h.sip != r.sip) || (r.en[5] && h.dip != r.dip) ||
             (r.en[6] && ((h.sip & r.mask) != r.pfx));
        f4 = (r.en[7] && h.proto != r.proto) ||
             (r.en[8] && (h.sport < r.sport_lo || h.sport > r.sport_hi)) ||
             (r.en[9] && (h.dport < r.dport_lo || h.dport > r.dport_hi));
        l = f2 ? 2'd1 : f3 ? 2'd2 : f4 ? 2'd3 : 2'd0;
        v = (l != 2'd0) ? 2'b01 : (r.rewrite ? 2'b10 : 2'b00);
    endfunction

    function automatic hdr_t rand_hdr();
        hdr_t h;
        h.flow  = FLOW_W'($urandom);
        h.smac  = {$urandom, $urandom};
        h.dmac  = {$urandom, $urandom};
        h.vlan  = VLAN_W'($urandom);
        h.etype = ETYPE_W'($urandom);
        h.sip   = $urandom;
        h.dip   = $urandom;
        h.proto = PROTO_W'($urandom);
        h.sport = PORT_W'($urandom);
        h.dport = PORT_W'($urandom);
        return h;
    endfunction

    function automatic rule_t match_rule(input hdr_t h);
        rule_t r;
        r.en       = '1;
        r.rewrite  = 1'b0;
        r.smac     = h.smac;
        r.dmac     = h.dmac;
        r.vlan     = h.vlan;
        r.etype    = h.etype;
        r.sip      = h.sip;
        r.dip      = h.dip;
        r.mask     = 32'hFFFF_FF00;
        r.pfx      = h.sip & 32'hFFFF_FF00;
        r.proto    = h.proto;
        r.sport_lo = h.sport;
        r.sport_hi = h.sport;
        r.dport_lo = h.dport;
        r.dport_hi = h.dport;
        return r;
    endfunction

    task automatic run_pkt(input hdr_t h, input rule_t r, input int idle, input string tag);
        logic [1:0] ev, el;
        model(h, r, ev, el);
        @(negedge clk);
        r_drv = r;
        rule_valid = 1'b1;
        chk(rule_ready === 1'b1, "R1", "rule_ready before rule", 64'(rule_ready), 1);
        @(negedge clk);
        rule_valid = 1'b0;
        r_drv = '1;
        for (int i = 0; i < idle; i++) @(negedge clk);
        chk(hdr_ready === 1'b1 && rule_ready === 1'b0, "R1", "armed readies",
            {hdr_ready, rule_ready}, 2'b10);
        h_drv = h;
        hdr_valid = 1'b1;
        @(negedge clk);
        hdr_valid = 1'b0;
        h_drv = '1;
        chk(hdr_ready === 1'b0 && rule_ready === 1'b1, "R1", "readies after header",
            {hdr_ready, rule_ready}, 2'b01);
        chk(out_valid === 1'b0, "R2", "out_valid early (1)", 64'(out_valid), 0);
        @(negedge clk);
        chk(out_valid === 1'b0, "R2", "out_valid early (2)", 64'(out_valid), 0);
        @(negedge clk);
        chk(out_valid === 1'b1, "R2", "out_valid on time", 64'(out_valid), 1);
        chk(out_verdict === ev, tag, "verdict", 64'(out_verdict), 64'(ev));
        chk(out_layer === el, tag, "layer", 64'(out_layer), 64'(el));
        chk(out_flow === h.flow, "R10", "flow echo", 64'(out_flow), 64'(h.flow));
        @(negedge clk);
        chk(out_valid === 1'b0, "R2", "out_valid one cycle", 64'(out_valid), 0);
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        hdr_t h;
        rule_t r;
        void'($urandom(32'd4242));
        h_drv = '0;
        r_drv = '0;
        repeat (3) @(negedge clk);
        chk(out_valid === 1'b0, "R11", "out_valid in reset", 64'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rule_ready === 1'b1 && hdr_ready === 1'b0, "R1", "reset readies",
            {rule_ready, hdr_ready}, 2'b10);
        chk(out_valid === 1'b0, "R11", "out_valid after reset", 64'(out_valid), 0);

        // full match, accept then modify
        h = rand_hdr(); r = match_rule(h);
        run_pkt(h, r, 0, "R9");
        r.rewrite = 1'b1;
        run_pkt(h, r, 3, "R9");
        // wildcard everything with unrelated values
        h = rand_hdr(); r = match_rule(rand_hdr()); r.en = '0; r.rewrite = 1'b1;
        run_pkt(h, r, 5, "R8");
        // link layer mismatch
        h = rand_hdr(); r = match_rule(h); r.smac[7] = ~r.smac[7];
        run_pkt(h, r, 0, "R3");
        h = rand_hdr(); r = match_rule(h); r.etype = ~r.etype;
        run_pkt(h, r, 0, "R3");
        // vlan mismatch ignored, dip mismatch caught
        h = rand_hdr(); r = match_rule(h); r.en[2] = 1'b0; r.vlan = ~r.vlan;
        r.dip = ~r.dip;
        run_pkt(h, r, 0, "R4");
        // anti-spoof: pass with prefix, then fail
        h = rand_hdr(); r = match_rule(h); r.en[4] = 1'b0; r.sip = ~h.sip;
        r.mask = 32'hFFF0_0000; r.pfx = h.sip & 32'hFFF0_0000;
        run_pkt(h, r, 0, "R5");
        r.pfx[20] = ~r.pfx[20];
        run_pkt(h, r, 0, "R5");
        // port range boundaries
        h = rand_hdr(); h.sport = 16'd1000; h.dport = 16'd80; r = match_rule(h);
        r.sport_lo = 16'd1000; r.sport_hi = 16'd2000;
        r.dport_lo = 16'd10;   r.dport_hi = 16'd80;
        run_pkt(h, r, 0, "R6");
        h.sport = 16'd2000; h.dport = 16'd10;
        run_pkt(h, r, 0, "R6");
        h.sport = 16'd2001;
        run_pkt(h, r, 0, "R6");
        h.sport = 16'd999;
        run_pkt(h, r, 0, "R6");
        h.sport = 16'd1500; h.proto = ~r.proto;
        run_pkt(h, r, 0, "R6");
        // priority: link and transport both fail
        h = rand_hdr(); r = match_rule(h); r.vlan = ~r.vlan; r.proto = ~r.proto;
        run_pkt(h, r, 0, "R7");
        h = rand_hdr(); r = match_rule(h); r.dip = ~r.dip; r.dport_lo = h.dport + 16'd1;
        r.dport_hi = h.dport + 16'd5;
        run_pkt(h, r, 0, "R7");

        // constrained random
        for (int n = 0; n < 300; n++) begin
            logic [1:0] ev, el;
            h = rand_hdr(); r = match_rule(h);
            r.en = EN_W'($urandom | $urandom);
            r.rewrite = 1'($urandom);
            if ($urandom_range(7) == 0) r.smac[$urandom_range(47)] ^= 1'b1;
            if ($urandom_range(7) == 0) r.vlan ^= VLAN_W'($urandom | 1);
            if ($urandom_range(7) == 0) r.sip ^= 32'h1;
            if ($urandom_range(7) == 0) r.dip ^= 32'h8000_0000;
            r.mask = 32'hFFFF_FFFF << $urandom_range(32);
            r.pfx = h.sip & r.mask;
            if ($urandom_range(7) == 0) r.pfx ^= 32'h8000_0000;
            if ($urandom_range(7) == 0) r.proto ^= 8'h11;
            r.sport_lo = h.sport - PORT_W'($urandom_range(3));
            r.sport_hi = h.sport + PORT_W'($urandom_range(3));
            if ($urandom_range(7) == 0) r.sport_hi = h.sport - 16'd1;
            r.dport_lo = h.dport - PORT_W'($urandom_range(2));
            r.dport_hi = h.dport;
            if ($urandom_range(7) == 0) r.dport_lo = h.dport + 16'd1;
            model(h, r, ev, el);
            run_pkt(h, r, $urandom_range(2),
                    el == 2'd1 ? "R3" : el == 2'd2 ? "R4" : el == 2'd3 ? "R6" : "R9");
        end

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule